// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a 32-bit core whose visible registers change with the processor mode. Software names sixteen logical registers through a 4-bit index. The block turns each index into one of its physical registers, using a 5-bit mode code. Index 15 is the program counter. Indices 13 and 14 are the stack and link registers. A fast-interrupt mode adds its own copies of indices 8 to 12. The block also holds the current status word and one saved status word for each privileged mode that has one.

Two combinational read ports and one write port serve the general registers. A separate port reads and writes the saved status word of the active mode, and another port serves the current status word. A user-bank override input makes general-register accesses use the user mapping. A privileged routine uses it to reach the user task's registers during block transfers. Every storage element sits behind a plain enable. No handshake is needed, because a read completes in the same cycle and a write always lands at the next rising edge.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every physical register to zero: all general registers in every bank, the program counter, the current status word and all saved status words.
- R2: Logical indices 0 to 7 name the same physical register in every mode.
- R3: Logical indices 8 to 12 name a private copy in fast-interrupt mode (code 5'b10001). Every other mode shares one common copy.
- R4: Logical indices 13 and 14 name a private pair in each of the fast-interrupt, interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes. User (5'b10000) and system (5'b11111) modes share one pair.
- R5: Logical index 15 is the program counter, a single register shared by all modes.
- R6: A mode code outside the seven listed in R3 and R4 behaves exactly like user mode for every port.
- R7: Each of the five modes with a private pair in R4 also has its own saved status word. The saved-status port reads and writes the word of the current mode.
- R8: In user and system modes, and in any code treated as user, the saved-status port reads zero and a write to it changes no saved status word.
- R9: While `user_bank` is high, the general-register read and write ports use the user-mode mapping whatever the mode. The saved-status port still follows the real mode.
- R10: A write becomes visible only after the rising edge at which it is applied. A read of the same register in the write cycle returns the old value.
- R11: The current status word is one register shared by all modes. It is loaded from `cs_wr_data` when `cs_wr_en` is high and follows the same timing as R10.
- R12: The two general-register read ports are independent. Each returns the register named by its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 5 | Current processor mode code |
| user_bank | input | 1 | Use the user-mode mapping for general-register accesses |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Register data, read port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Register data, read port B |
| wr_en | input | 1 | General-register write enable |
| wr_idx | input | 4 | Logical index for the write |
| wr_data | input | 32 | Write data |
| sv_wr_en | input | 1 | Saved-status write enable |
| sv_wr_data | input | 32 | Saved-status write data |
| sv_rd_data | output | 32 | Saved status word of the current mode, or zero |
| cs_wr_en | input | 1 | Current-status write enable |
| cs_wr_data | input | 32 | Current-status write data |
| cs_rd_data | output | 32 | Current status word |

## Verification
The assertions check the following on every cycle:
- The saved-status port reads zero and keeps its contents frozen whenever the mode has no saved word.
- A write from any non-fast-interrupt mode leaves the fast-interrupt copies of indices 8 to 12 unchanged.
- A write to index 13 or 14 never disturbs the user pair from another bank.
- Both ports agree on the program counter.
- Every port reads zero on the cycle after reset.

Only the bench's scenarios can show the full aliasing picture: which modes share a physical register and which do not. The bench shows this by writing a distinct value through every index in every mode and reading all of them back. The bench also covers three other cases:
- the old-value-then-new-value order on a read during a write;
- the override reaching the user pair from a privileged mode;
- unlisted mode codes falling back to user mode.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int MODE_W    = 5;
  localparam int IDX_W     = 4;
  localparam int NUM_BANKS = 6;
  localparam int NUM_SAVED = NUM_BANKS - 1;
  localparam int LOW_N     = 8;
  localparam int HI_N      = 5;
  localparam int HI_BASE   = LOW_N;
  localparam int SP_IDX    = HI_BASE + HI_N;
  localparam int LR_IDX    = SP_IDX + 1;
  localparam int PC_IDX    = LR_IDX + 1;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  // bank 0 is shared by user and system; banks 1..5 map to saved slots 0..4
  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;
endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
  import rf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              user_bank,
  output bank_e             reg_bank,
  output bank_e             stat_bank,
  output logic              has_saved
);
  bank_e true_bank;

  always_comb begin
    case (mode)
      MODE_FIQ: true_bank = BK_FIQ;
      MODE_IRQ: true_bank = BK_IRQ;
      MODE_SVC: true_bank = BK_SVC;
      MODE_ABT: true_bank = BK_ABT;
      MODE_UND: true_bank = BK_UND;
      default:  true_bank = BK_USR; // user, system and unlisted codes (R6)
    endcase
  end

  assign reg_bank  = user_bank ? BK_USR : true_bank; // R9
  assign stat_bank = true_bank;
  assign has_saved = (true_bank != BK_USR);
endmodule

// File: rtl/rf_gpr_bank.sv
module rf_gpr_bank
  import rf_pkg::*;
#(
  parameter int DW      = 32,
  parameter int N_RPORT = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  bank_e                        bank,
  input  logic [N_RPORT-1:0][IDX_W-1:0] rd_idx,
  output logic [N_RPORT-1:0][DW-1:0]    rd_data,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DW-1:0]                wr_data
);
  localparam int LOW_W = $clog2(LOW_N);
  localparam int HI_W  = $clog2(HI_N);

  logic [LOW_N-1:0][DW-1:0]         low_q;
  logic [1:0][HI_N-1:0][DW-1:0]     hi_q;   // [0] common, [1] fast-interrupt
  logic [NUM_BANKS-1:0][DW-1:0]     sp_q;
  logic [NUM_BANKS-1:0][DW-1:0]     lr_q;
  logic [DW-1:0]                    pc_q;

  logic hi_sel;
  assign hi_sel = (bank == BK_FIQ);

  logic [IDX_W-1:0] wr_hoff;
  assign wr_hoff = wr_idx - IDX_W'(HI_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q <= '0;
      hi_q  <= '0;
      sp_q  <= '0;
      lr_q  <= '0;
      pc_q  <= '0;
    end else if (wr_en) begin
      if (int'(wr_idx) < HI_BASE)
        low_q[wr_idx[LOW_W-1:0]] <= wr_data;
      else if (int'(wr_idx) < SP_IDX)
        hi_q[hi_sel][wr_hoff[HI_W-1:0]] <= wr_data;
      else if (int'(wr_idx) == SP_IDX)
        sp_q[bank] <= wr_data;
      else if (int'(wr_idx) == LR_IDX)
        lr_q[bank] <= wr_data;
      else
        pc_q <= wr_data;
    end
  end

  for (genvar p = 0; p < N_RPORT; p++) begin : g_rport
    logic [IDX_W-1:0] hoff;
    assign hoff = rd_idx[p] - IDX_W'(HI_BASE);
    always_comb begin
      if (int'(rd_idx[p]) < HI_BASE)
        rd_data[p] = low_q[rd_idx[p][LOW_W-1:0]];
      else if (int'(rd_idx[p]) < SP_IDX)
        rd_data[p] = hi_q[hi_sel][hoff[HI_W-1:0]];
      else if (int'(rd_idx[p]) == SP_IDX)
        rd_data[p] = sp_q[bank];
      else if (int'(rd_idx[p]) == LR_IDX)
        rd_data[p] = lr_q[bank];
      else
        rd_data[p] = pc_q;
    end
  end

  // R3: writes outside fast-interrupt bank never reach its private high copies
  p_fiq_private_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hi_sel) |=> $stable(hi_q[1]));

  // R4: a banked-mode write to the stack/link index leaves the user pair alone
  p_user_pair_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bank != BK_USR && int'(wr_idx) >= SP_IDX && int'(wr_idx) <= LR_IDX)
    |=> ($stable(sp_q[BK_USR]) && $stable(lr_q[BK_USR])));
endmodule

// File: rtl/rf_status_bank.sv
module rf_status_bank
  import rf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  bank_e         stat_bank,
  input  logic          has_saved,
  input  logic          sv_wr_en,
  input  logic [DW-1:0] sv_wr_data,
  output logic [DW-1:0] sv_rd_data,
  input  logic          cs_wr_en,
  input  logic [DW-1:0] cs_wr_data,
  output logic [DW-1:0] cs_rd_data
);
  localparam int SLOT_W = $clog2(NUM_SAVED);

  logic [NUM_SAVED-1:0][DW-1:0] saved_q;
  logic [DW-1:0]                cur_q;
  logic [2:0]                   slot_full;
  logic [SLOT_W-1:0]            slot;

  assign slot_full = 3'(stat_bank) - 3'd1;
  assign slot      = slot_full[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      saved_q <= '0;
      cur_q   <= '0;
    end else begin
      if (sv_wr_en && has_saved) saved_q[slot] <= sv_wr_data;
      if (cs_wr_en)              cur_q         <= cs_wr_data;
    end
  end

  assign sv_rd_data = has_saved ? saved_q[slot] : '0;
  assign cs_rd_data = cur_q;

  p_nosave_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !has_saved |-> (sv_rd_data == '0));

  p_nosave_write_dropped_r8: assert property (@(posedge clk) disable iff (rst)
    (!has_saved && sv_wr_en) |=> $stable(saved_q));

  p_cur_status_load_r11: assert property (@(posedge clk) disable iff (rst)
    cs_wr_en |=> (cs_rd_data == $past(cs_wr_data)));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              user_bank,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DW-1:0]     rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DW-1:0]     rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic              sv_wr_en,
  input  logic [DW-1:0]     sv_wr_data,
  output logic [DW-1:0]     sv_rd_data,
  input  logic              cs_wr_en,
  input  logic [DW-1:0]     cs_wr_data,
  output logic [DW-1:0]     cs_rd_data
);
  bank_e reg_bank;
  bank_e stat_bank;
  logic  has_saved;

  rf_mode_decode u_decode (
    .mode      (mode),
    .user_bank (user_bank),
    .reg_bank  (reg_bank),
    .stat_bank (stat_bank),
    .has_saved (has_saved)
  );

  logic [1:0][IDX_W-1:0] rd_idx;
  logic [1:0][DW-1:0]    rd_data;
  assign rd_idx    = {rd_b_idx, rd_a_idx};
  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];

  rf_gpr_bank #(.DW(DW), .N_RPORT(2)) u_gpr (
    .clk     (clk),
    .rst     (rst),
    .bank    (reg_bank),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data)
  );

  rf_status_bank #(.DW(DW)) u_status (
    .clk        (clk),
    .rst        (rst),
    .stat_bank  (stat_bank),
    .has_saved  (has_saved),
    .sv_wr_en   (sv_wr_en),
    .sv_wr_data (sv_wr_data),
    .sv_rd_data (sv_rd_data),
    .cs_wr_en   (cs_wr_en),
    .cs_wr_data (cs_wr_data),
    .cs_rd_data (cs_rd_data)
  );

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd_a_data == '0 && rd_b_data == '0 &&
                    sv_rd_data == '0 && cs_rd_data == '0));

  p_pc_shared_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_a_idx) == PC_IDX && int'(rd_b_idx) == PC_IDX) |-> (rd_a_data == rd_b_data));
endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  mode = 5'b10000;
  logic        user_bank = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, sv_wr_en = 1'b0, cs_wr_en = 1'b0;
  logic [31:0] sv_wr_data = '0, sv_rd_data, cs_wr_data = '0, cs_rd_data;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst(rst), .mode(mode), .user_bank(user_bank),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sv_wr_en(sv_wr_en), .sv_wr_data(sv_wr_data), .sv_rd_data(sv_rd_data),
    .cs_wr_en(cs_wr_en), .cs_wr_data(cs_wr_data), .cs_rd_data(cs_rd_data)
  );

  // position order: usr, fiq, irq, svc, abt, und, sys
  logic [4:0] md [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};

  function automatic logic [31:0] tagv(int p, int i);
    return 32'hA500_0000 | 32'((p + 1) << 16) | 32'(p << 8) | 32'(i);
  endfunction

  // last write position (writes go in position order) that shares storage with p at index i
  function automatic int last_writer(int p, int i);
    if (i == 13 || i == 14) return (p == 0 || p == 6) ? 6 : p;
    if (i >= 8 && i <= 12)  return (p == 1) ? 1 : 6;
    return 6;
  endfunction

  function automatic string req_of(int i);
    if (i < 8)  return "R2";
    if (i < 13) return "R3";
    if (i < 15) return "R4";
    return "R5";
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr_gpr(logic [4:0] m, logic ob, int i, logic [31:0] d);
    @(negedge clk);
    mode = m; user_bank = ob; wr_en = 1'b1; wr_idx = 4'(i); wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; user_bank = 1'b0;
  endtask

  task automatic rd_gpr(string rq, logic [4:0] m, logic ob, int i, logic [31:0] exp);
    @(negedge clk);
    mode = m; user_bank = ob; rd_a_idx = 4'(i); rd_b_idx = 4'(i);
    #2;
    chk(rq, rd_a_data, exp);
    chk(rq, rd_b_data, exp);
    user_bank = 1'b0;
  endtask

  task automatic wr_sv(logic [4:0] m, logic [31:0] d);
    @(negedge clk);
    mode = m; sv_wr_en = 1'b1; sv_wr_data = d;
    @(posedge clk); #1;
    sv_wr_en = 1'b0;
  endtask

  task automatic rd_sv(string rq, logic [4:0] m, logic [31:0] exp);
    @(negedge clk);
    mode = m; #2;
    chk(rq, sv_rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: everything reads zero after reset
    for (int p = 0; p < 7; p++) begin
      rd_gpr("R1", md[p], 1'b0, 0, 32'h0);
      rd_gpr("R1", md[p], 1'b0, 9, 32'h0);
      rd_gpr("R1", md[p], 1'b0, 14, 32'h0);
      rd_gpr("R1", md[p], 1'b0, 15, 32'h0);
      rd_sv("R1", md[p], 32'h0);
    end
    @(negedge clk); #2; chk("R1", cs_rd_data, 32'h0);

    // sweep: every index written in every mode, in position order
    for (int p = 0; p < 7; p++)
      for (int i = 0; i < 16; i++)
        wr_gpr(md[p], 1'b0, i, tagv(p, i));
    for (int p = 0; p < 7; p++)
      for (int i = 0; i < 16; i++)
        rd_gpr(req_of(i), md[p], 1'b0, i, tagv(last_writer(p, i), i));

    // R6: unlisted codes behave as user
    rd_gpr("R6", 5'b00000, 1'b0, 13, tagv(6, 13));
    rd_gpr("R6", 5'b10101, 1'b0, 9, tagv(6, 9));
    rd_sv("R6", 5'b01011, 32'h0);
    wr_gpr(5'b00111, 1'b0, 14, 32'h0BAD_0014);
    rd_gpr("R6", md[6], 1'b0, 14, 32'h0BAD_0014);
    rd_gpr("R6", md[3], 1'b0, 14, tagv(3, 14));

    // R9: override forces the user mapping
    rd_gpr("R9", md[3], 1'b1, 13, tagv(6, 13));
    rd_gpr("R9", md[1], 1'b1, 10, tagv(6, 10));
    wr_gpr(md[2], 1'b1, 13, 32'hC0DE_0013);
    rd_gpr("R9", md[0], 1'b0, 13, 32'hC0DE_0013);
    rd_gpr("R9", md[2], 1'b0, 13, tagv(2, 13));

    // R10 / R12: read during write returns old, new value next cycle
    @(negedge clk);
    mode = md[0]; wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h1357_9BDF;
    rd_a_idx = 4'd3; rd_b_idx = 4'd4;
    #2;
    chk("R10", rd_a_data, tagv(6, 3));
    chk("R12", rd_b_data, tagv(6, 4));
    @(posedge clk); #1; wr_en = 1'b0;
    @(negedge clk); #2;
    chk("R10", rd_a_data, 32'h1357_9BDF);
    chk("R12", rd_b_data, tagv(6, 4));

    // R7 / R8: saved status words
    for (int p = 1; p < 6; p++) wr_sv(md[p], 32'h5A00_0000 | 32'(p));
    wr_sv(md[0], 32'hDEAD_0000);
    wr_sv(md[6], 32'hDEAD_0006);
    for (int p = 0; p < 7; p++)
      rd_sv((p == 0 || p == 6) ? "R8" : "R7", md[p],
            (p == 0 || p == 6) ? 32'h0 : (32'h5A00_0000 | 32'(p)));
    @(negedge clk); mode = md[3]; user_bank = 1'b1; #2;
    chk("R9", sv_rd_data, 32'h5A00_0003);
    user_bank = 1'b0;

    // R11: current status word timing
    @(negedge clk);
    mode = md[4]; cs_wr_en = 1'b1; cs_wr_data = 32'h0000_00D3; #2;
    chk("R11", cs_rd_data, 32'h0);
    @(posedge clk); #1; cs_wr_en = 1'b0;
    @(negedge clk); mode = md[0]; #2;
    chk("R11", cs_rd_data, 32'h0000_00D3);

    // R1: reset mid-run
    do_reset();
    rd_gpr("R1", md[3], 1'b0, 13, 32'h0);
    rd_gpr("R1", md[1], 1'b0, 11, 32'h0);
    rd_gpr("R1", md[0], 1'b0, 3, 32'h0);
    rd_sv("R1", md[3], 32'h0);
    @(negedge clk); #2; chk("R1", cs_rd_data, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule